// File: doc/BRIEF.md
# USB Device IN Transaction Responder

This block is the transaction layer of a full-speed USB device engine for IN transfers on 16 endpoints. A packet layer hands it tokens that are already decoded into PID, device address and endpoint number. It also hands it handshake PIDs from the host and a pulse when a data packet has left the wire. For each IN token aimed at this device and at an enabled endpoint, the block decides whether to send that endpoint's buffered data or a NAK. It then follows the handshake phase and keeps the per-endpoint buffer-full flags, data toggles and interrupt bits.

The response leaves on a valid/ready stream. The block raises `resp_valid` with the PID to send and the endpoint. It holds both stable until the packet layer takes them with `resp_ready`. The block never back-pressures tokens. A token that arrives while a transaction is open is consumed and dropped. A microprocessor marks an endpoint full after loading its buffer, using `cpu_fill_valid`. It reads `irq_bits` and pulses `cpu_irq_rd` to clear the bits it saw.

Top module: `usbdev_in_responder`

## Requirements
- R1: An IN token (PID 4'b1001) whose address equals `dev_addr`, for an enabled endpoint whose buffer is full, gets a data response. The PID is DATA0 (4'b0011) when the endpoint toggle is 0 and DATA1 (4'b1011) when it is 1.
- R2: An IN token that passes the address and enable checks for an endpoint whose buffer is empty gets a NAK response (PID 4'b1010).
- R3: No response is produced for a token with a non-IN PID, a wrong address or a disabled endpoint. None is produced for a token that arrives while a transaction is open.
- R4: For a non-isochronous endpoint, after `tx_done` the block waits for an ACK (PID 4'b0010). On that ACK it clears the endpoint's full flag, sets its interrupt bit and flips its toggle. Before the ACK, full stays set and the interrupt bit stays clear.
- R5: For an isochronous endpoint (`ep_iso` bit set), the full flag is cleared and the interrupt bit is set on `tx_done`. The data PID is always DATA0.
- R6: If no ACK arrives within HS_TIMEOUT cycles after `tx_done`, the endpoint stays full, no interrupt bit is set and the toggle is kept. The next IN resends with the same data PID.
- R7: `irq` is the OR of `irq_bits`. A `cpu_irq_rd` pulse clears every bit shown in that cycle. A bit set by a completion in the same cycle survives.
- R8: `cpu_fill_valid` marks endpoint `cpu_fill_ep` full, so the next IN token for it gets data.
- R9: While `resp_valid` is high and `resp_ready` is low, `resp_valid`, `resp_pid` and `resp_ep` hold their values.
- R10: After reset every endpoint is empty with toggle 0, every interrupt bit is clear and `resp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_addr | input | 7 | Address assigned to this device |
| ep_enable | input | 16 | Per-endpoint enable |
| ep_iso | input | 16 | Per-endpoint isochronous flag |
| tok_valid | input | 1 | Decoded token present this cycle |
| tok_pid | input | 4 | Token PID |
| tok_addr | input | 7 | Token device address |
| tok_ep | input | 4 | Token endpoint number |
| hs_valid | input | 1 | Handshake packet from the host present |
| hs_pid | input | 4 | Handshake PID |
| resp_valid | output | 1 | Response to send is pending |
| resp_ready | input | 1 | Packet layer takes the response |
| resp_pid | output | 4 | PID to send (DATA0, DATA1 or NAK) |
| resp_ep | output | 4 | Endpoint whose buffer supplies the data |
| tx_done | input | 1 | Data packet has been fully sent |
| cpu_fill_valid | input | 1 | Processor marks an endpoint buffer full |
| cpu_fill_ep | input | 4 | Endpoint to mark full |
| cpu_irq_rd | input | 1 | Processor read of the interrupt bits; clears them |
| ep_full | output | 16 | Per-endpoint buffer-full status |
| irq_bits | output | 16 | Per-endpoint completion interrupt bits |
| irq | output | 1 | Any interrupt bit set |

## Verification
The assertions assume three things about the inputs. `ep_iso` and `ep_enable` stay constant while a transaction is open. `tx_done` comes only after a data response has been taken. The packet layer does not withdraw a response it has not taken. The bench sets the endpoint configuration once before traffic and pulses `tx_done` only after a data response has been taken. It raises `resp_ready` only while a response is shown, so every stimulus stays inside these assumptions.

// File: rtl/usbin_pkg.sv
package usbin_pkg;
  localparam logic [3:0] PID_IN    = 4'b1001;
  localparam logic [3:0] PID_ACK   = 4'b0010;
  localparam logic [3:0] PID_NAK   = 4'b1010;
  localparam logic [3:0] PID_DATA0 = 4'b0011;
  localparam logic [3:0] PID_DATA1 = 4'b1011;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESP,
    ST_TX,
    ST_ACK
  } txn_st_e;
endpackage

// File: rtl/usbin_fsm.sv
module usbin_fsm
  import usbin_pkg::*;
#(
  parameter int NUM_EP     = 16,
  parameter int EPW        = 4,
  parameter int ADDRW      = 7,
  parameter int HS_TIMEOUT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDRW-1:0]  dev_addr,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic [NUM_EP-1:0] ep_full,
  input  logic [NUM_EP-1:0] ep_toggle,
  input  logic              tok_valid,
  input  logic [3:0]        tok_pid,
  input  logic [ADDRW-1:0]  tok_addr,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              hs_valid,
  input  logic [3:0]        hs_pid,
  input  logic              resp_ready,
  input  logic              tx_done,
  output logic              resp_valid,
  output logic [3:0]        resp_pid,
  output logic [EPW-1:0]    resp_ep,
  output logic              cmp_valid,
  output logic [EPW-1:0]    cmp_ep,
  output logic              cmp_flip
);
  localparam int CNTW = (HS_TIMEOUT > 1) ? $clog2(HS_TIMEOUT) : 1;
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(HS_TIMEOUT - 1);

  txn_st_e          st;
  logic [EPW-1:0]   cur_ep;
  logic [3:0]       cur_pid;
  logic             cur_data;
  logic             cur_iso;
  logic [CNTW-1:0]  cnt;
  logic             accept;
  logic             got_ack;

  assign accept  = (st == ST_IDLE) && tok_valid && (tok_pid == PID_IN) &&
                   (tok_addr == dev_addr) && ep_enable[tok_ep];
  assign got_ack = (st == ST_ACK) && hs_valid && (hs_pid == PID_ACK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_ep   <= '0;
      cur_pid  <= PID_NAK;
      cur_data <= 1'b0;
      cur_iso  <= 1'b0;
      cnt      <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (accept) begin
          cur_ep   <= tok_ep;
          cur_data <= ep_full[tok_ep];
          cur_iso  <= ep_iso[tok_ep];
          if (!ep_full[tok_ep])                         cur_pid <= PID_NAK;
          else if (ep_iso[tok_ep] || !ep_toggle[tok_ep]) cur_pid <= PID_DATA0;
          else                                           cur_pid <= PID_DATA1;
          st <= ST_RESP;
        end
        ST_RESP: if (resp_ready) st <= cur_data ? ST_TX : ST_IDLE;
        ST_TX: if (tx_done) begin
          cnt <= '0;
          st  <= cur_iso ? ST_IDLE : ST_ACK;
        end
        ST_ACK: begin
          if (got_ack || cnt == CNT_LAST) st <= ST_IDLE;
          else                            cnt <= cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign resp_valid = (st == ST_RESP);
  assign resp_pid   = cur_pid;
  assign resp_ep    = cur_ep;
  assign cmp_valid  = ((st == ST_TX) && tx_done && cur_iso) || got_ack;
  assign cmp_ep     = cur_ep;
  assign cmp_flip   = !cur_iso;

  a_r9_resp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_ready |=> resp_valid && $stable(resp_pid) && $stable(resp_ep));
  a_r1_data_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_pid != PID_NAK |-> ep_full[resp_ep]);
  a_r5_iso_data0: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && ep_iso[resp_ep] |-> resp_pid != PID_DATA1);
  a_r3_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |-> ep_enable[resp_ep]);
endmodule

// File: rtl/usbin_epstat.sv
module usbin_epstat #(
  parameter int NUM_EP = 16,
  parameter int EPW    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fill_valid,
  input  logic [EPW-1:0]    fill_ep,
  input  logic              cmp_valid,
  input  logic [EPW-1:0]    cmp_ep,
  input  logic              cmp_flip,
  input  logic              irq_rd,
  output logic [NUM_EP-1:0] ep_full,
  output logic [NUM_EP-1:0] ep_toggle,
  output logic [NUM_EP-1:0] irq_bits
);
  for (genvar gi = 0; gi < NUM_EP; gi++) begin : g_ep
    logic hit_cmp;
    logic hit_fill;
    assign hit_cmp  = cmp_valid && (cmp_ep == EPW'(gi));
    assign hit_fill = fill_valid && (fill_ep == EPW'(gi));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ep_full[gi]   <= 1'b0;
        ep_toggle[gi] <= 1'b0;
        irq_bits[gi]  <= 1'b0;
      end else begin
        if (hit_fill)     ep_full[gi] <= 1'b1;
        else if (hit_cmp) ep_full[gi] <= 1'b0;
        if (hit_cmp && cmp_flip) ep_toggle[gi] <= !ep_toggle[gi];
        irq_bits[gi] <= hit_cmp || (irq_bits[gi] && !irq_rd);
      end
    end
  end

  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rd && !cmp_valid |=> irq_bits == '0);
  a_r4_cmp_empties: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_valid && !(fill_valid && fill_ep == cmp_ep) |=> !ep_full[$past(cmp_ep)] && irq_bits[$past(cmp_ep)]);
  a_r8_fill_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |=> ep_full[$past(fill_ep)]);
endmodule

// File: rtl/usbdev_in_responder.sv
module usbdev_in_responder #(
  parameter int NUM_EP     = 16,
  parameter int ADDRW      = 7,
  parameter int HS_TIMEOUT = 16,
  localparam int EPW       = $clog2(NUM_EP)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDRW-1:0]  dev_addr,
  input  logic [NUM_EP-1:0] ep_enable,
  input  logic [NUM_EP-1:0] ep_iso,
  input  logic              tok_valid,
  input  logic [3:0]        tok_pid,
  input  logic [ADDRW-1:0]  tok_addr,
  input  logic [EPW-1:0]    tok_ep,
  input  logic              hs_valid,
  input  logic [3:0]        hs_pid,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [3:0]        resp_pid,
  output logic [EPW-1:0]    resp_ep,
  input  logic              tx_done,
  input  logic              cpu_fill_valid,
  input  logic [EPW-1:0]    cpu_fill_ep,
  input  logic              cpu_irq_rd,
  output logic [NUM_EP-1:0] ep_full,
  output logic [NUM_EP-1:0] irq_bits,
  output logic              irq
);
  logic [NUM_EP-1:0] ep_toggle;
  logic              cmp_valid;
  logic [EPW-1:0]    cmp_ep;
  logic              cmp_flip;

  usbin_fsm #(.NUM_EP(NUM_EP), .EPW(EPW), .ADDRW(ADDRW), .HS_TIMEOUT(HS_TIMEOUT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .ep_enable(ep_enable),
    .ep_iso(ep_iso), .ep_full(ep_full), .ep_toggle(ep_toggle),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .hs_valid(hs_valid), .hs_pid(hs_pid), .resp_ready(resp_ready), .tx_done(tx_done),
    .resp_valid(resp_valid), .resp_pid(resp_pid), .resp_ep(resp_ep),
    .cmp_valid(cmp_valid), .cmp_ep(cmp_ep), .cmp_flip(cmp_flip)
  );

  usbin_epstat #(.NUM_EP(NUM_EP), .EPW(EPW)) u_stat (
    .clk(clk), .rst_n(rst_n), .fill_valid(cpu_fill_valid), .fill_ep(cpu_fill_ep),
    .cmp_valid(cmp_valid), .cmp_ep(cmp_ep), .cmp_flip(cmp_flip), .irq_rd(cpu_irq_rd),
    .ep_full(ep_full), .ep_toggle(ep_toggle), .irq_bits(irq_bits)
  );

  assign irq = |irq_bits;

  a_r7_irq_follows_bits: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (irq_bits != '0));
endmodule

// File: tb/sim_usbdev_in_responder.sv
`timescale 1ns/1ps
module sim_usbdev_in_responder;
  localparam int TO = 16;
  localparam logic [6:0] MYADDR = 7'd5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [6:0]  dev_addr = MYADDR;
  logic [15:0] ep_enable = 16'h00FF;
  logic [15:0] ep_iso = 16'h0004;
  logic tok_valid = 0; logic [3:0] tok_pid = 0; logic [6:0] tok_addr = 0; logic [3:0] tok_ep = 0;
  logic hs_valid = 0; logic [3:0] hs_pid = 0;
  logic resp_valid; logic resp_ready = 0; logic [3:0] resp_pid; logic [3:0] resp_ep;
  logic tx_done = 0;
  logic cpu_fill_valid = 0; logic [3:0] cpu_fill_ep = 0; logic cpu_irq_rd = 0;
  logic [15:0] ep_full, irq_bits; logic irq;

  int checks = 0;
  int fails = 0;

  always #10 clk = ~clk;

  usbdev_in_responder #(.HS_TIMEOUT(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .dev_addr(dev_addr), .ep_enable(ep_enable), .ep_iso(ep_iso),
    .tok_valid(tok_valid), .tok_pid(tok_pid), .tok_addr(tok_addr), .tok_ep(tok_ep),
    .hs_valid(hs_valid), .hs_pid(hs_pid), .resp_valid(resp_valid), .resp_ready(resp_ready),
    .resp_pid(resp_pid), .resp_ep(resp_ep), .tx_done(tx_done),
    .cpu_fill_valid(cpu_fill_valid), .cpu_fill_ep(cpu_fill_ep), .cpu_irq_rd(cpu_irq_rd),
    .ep_full(ep_full), .irq_bits(irq_bits), .irq(irq)
  );

  // {pid[4], addr[7], ep[4], kind[2] (0 none,1 NAK,2 DATA0,3 DATA1), ack, full_after, irq_after}
  localparam int NV = 9;
  localparam logic [19:0] VEC [NV] = '{
    {4'b1001, 7'd5, 4'd3, 2'd1, 1'b0, 1'b0, 1'b0},  // R2 empty enabled ep -> NAK
    {4'b1001, 7'd6, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0},  // R3 wrong address
    {4'b0001, 7'd5, 4'd1, 2'd0, 1'b0, 1'b1, 1'b0},  // R3 non-IN PID
    {4'b1001, 7'd5, 4'd9, 2'd0, 1'b0, 1'b1, 1'b0},  // R3 disabled ep
    {4'b1001, 7'd5, 4'd1, 2'd2, 1'b0, 1'b1, 1'b0},  // R6 no ACK, timeout
    {4'b1001, 7'd5, 4'd1, 2'd2, 1'b1, 1'b0, 1'b1},  // R6 resend DATA0, R4 ACK
    {4'b1001, 7'd5, 4'd1, 2'd1, 1'b0, 1'b0, 1'b1},  // R2 emptied -> NAK
    {4'b1001, 7'd5, 4'd2, 2'd2, 1'b0, 1'b0, 1'b1},  // R5 iso completes on tx_done
    {4'b1001, 7'd5, 4'd2, 2'd1, 1'b0, 1'b0, 1'b1}   // R2 iso emptied
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic fill(input logic [3:0] ep);
    cpu_fill_valid = 1; cpu_fill_ep = ep; tick(); cpu_fill_valid = 0;
  endtask

  task automatic token(input logic [3:0] pid, input logic [6:0] addr, input logic [3:0] ep);
    tok_valid = 1; tok_pid = pid; tok_addr = addr; tok_ep = ep; tick(); tok_valid = 0;
  endtask

  task automatic take(); resp_ready = 1; tick(); resp_ready = 0; endtask
  task automatic send_tx(); tx_done = 1; tick(); tx_done = 0; endtask
  task automatic send_ack(); hs_valid = 1; hs_pid = 4'b0010; tick(); hs_valid = 0; endtask

  function automatic logic [3:0] kind_pid(input logic [1:0] k);
    return (k == 2'd1) ? 4'b1010 : (k == 2'd2) ? 4'b0011 : 4'b1011;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (3) tick();
    rst_n = 1; tick();
    check(!resp_valid, "R10 resp_valid", resp_valid, 0);
    check(ep_full == 0, "R10 ep_full", ep_full, 0);
    check(irq_bits == 0 && !irq, "R10 irq", irq_bits, 0);

    fill(4'd1); fill(4'd2); fill(4'd9);
    check(ep_full == 16'h0206, "R8 fill", ep_full, 16'h0206);

    for (int i = 0; i < NV; i++) begin
      logic [3:0] pid; logic [6:0] addr; logic [3:0] ep; logic [1:0] kind;
      logic ack, fexp, iexp;
      {pid, addr, ep, kind, ack, fexp, iexp} = VEC[i];
      token(pid, addr, ep);
      if (kind == 0) begin
        for (int k = 0; k < 3; k++) begin
          check(!resp_valid, "R3 silent", resp_valid, 0);
          tick();
        end
      end else begin
        check(resp_valid && resp_pid == kind_pid(kind) && resp_ep == ep,
              (kind == 1) ? "R2 nak" : "R1 data", {resp_valid, resp_pid}, {1'b1, kind_pid(kind)});
        take();
        if (kind != 1) begin
          send_tx();
          if (!ep_iso[ep]) begin
            check(ep_full[ep] && !irq_bits[ep], "R4 wait for ack", {ep_full[ep], irq_bits[ep]}, 2);
            if (ack) begin tick(); send_ack(); end
            else repeat (TO + 4) tick();
          end
        end
      end
      check(ep_full[ep] == fexp && irq_bits[ep] == iexp, "R4/R5/R6 status",
            {ep_full[ep], irq_bits[ep]}, {fexp, iexp});
    end

    // R7: aggregate irq and read-clear
    check(irq && irq_bits == 16'h0006, "R7 irq or", {irq, irq_bits}, {1'b1, 16'h0006});
    cpu_irq_rd = 1; tick(); cpu_irq_rd = 0;
    check(!irq && irq_bits == 0, "R7 read clears", {irq, irq_bits}, 0);

    // R8 refill, R1 toggle advanced to DATA1, R3 busy token ignored, R7 same-cycle set kept
    fill(4'd1);
    token(4'b1001, MYADDR, 4'd1);
    check(resp_valid && resp_pid == 4'b1011, "R1 DATA1 after ack", resp_pid, 4'hB);
    take(); send_tx();
    token(4'b1001, MYADDR, 4'd3);
    check(!resp_valid, "R3 busy token", resp_valid, 0);
    tick();
    check(!resp_valid, "R3 busy token later", resp_valid, 0);
    hs_valid = 1; hs_pid = 4'b0010; cpu_irq_rd = 1; tick(); hs_valid = 0; cpu_irq_rd = 0;
    check(irq_bits == 16'h0002 && irq, "R7 set beats read", irq_bits, 16'h0002);
    cpu_irq_rd = 1; tick(); cpu_irq_rd = 0;
    check(irq_bits == 0, "R7 second read", irq_bits, 0);

    // R9 hold under back-pressure; toggle back to DATA0
    fill(4'd1);
    token(4'b1001, MYADDR, 4'd1);
    for (int k = 0; k < 3; k++) begin
      check(resp_valid && resp_pid == 4'b0011 && resp_ep == 4'd1, "R9 hold",
            {resp_valid, resp_pid, resp_ep}, {1'b1, 4'b0011, 4'd1});
      tick();
    end
    take(); send_tx(); send_ack();
    check(!ep_full[1] && irq_bits[1], "R4 ack completes", {ep_full[1], irq_bits[1]}, 1);
    check(!resp_valid, "R9 released", resp_valid, 0);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule